// File: doc/BRIEF.md
# Capture Event and Overflow Linkage Router

This block sits between a small array of bandwidth monitor instances and the shared capture machinery around them. Six numbered event lines are shared by all monitors, and a software capture strobe (a register write tagged with a security state) stands beside them. Each monitor picks one source with a 3-bit capture selector. Each monitor can also broadcast its own overflow onto one of the six lines with a 3-bit linkage selector. Every cycle the router decides which monitors get a capture pulse and which get an overflow indication.

Each shared line is the OR of its external strobe and every overflow linked to it, and it is registered once. A capture therefore follows its cause by exactly one clock, whatever the cause was. A 6-bit parameter mask says which lines exist in the build. A line that does not exist never fires, whether it is driven by an external strobe or by a linked overflow. Two per-monitor controls shape the response. Capture-on-overflow turns the monitor's own overflow into a private capture. Event-as-overflow turns a matching event into an overflow indication instead of a capture.

Top module: `capevt_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with idle inputs, every bit of `capPulse` and `ovfEvt` is 0.
- R2: A monitor whose capture selector is 3'b000 gets no capture pulse and no overflow indication from any event source.
- R3: A capture selector value k in 3'b001..3'b110 gives the monitor a capture pulse in the cycle after `extEvt[k-1]` is high, provided line k is implemented (`EXT_MASK[k-1]` = 1).
- R4: A line whose `EXT_MASK` bit is 0 never produces a capture pulse or an overflow indication, whether the source is an external strobe or a linked overflow.
- R5: Selector 3'b111 gives a capture pulse in the cycle after `swCapWr`, but only when `swCapSec` equals that monitor's `monSec` slice.
- R6: A linkage selector value k in 3'b001..3'b110 makes the monitor's `ovfPulse` drive line k. Other monitors that select k then react in the next cycle, exactly as they would for an external strobe.
- R7: Linkage selector 3'b000 (overflow stays local) and 3'b111 (reserved) drive no shared line.
- R8: With `capOnOvf` = 1, a monitor's own `ovfPulse` gives it a capture pulse in the next cycle, whatever its selectors are.
- R9: With `evtAsOvf` = 1, a matching event (line or software) raises `ovfEvt` for one cycle. In that case `capPulse` is raised for the event only if `capOnOvf` = 1 as well.
- R10: A monitor whose own overflow drove line k gets no event from line k in the cycle that event lands, even if an external strobe coincided with it.
- R11: When an external strobe and linked overflows hit the same line in the same cycle, each selecting monitor gets a single one-cycle pulse, and the line is idle again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extEvt | input | 6 | External strobes for shared lines 1..6 (bit k-1 is line k) |
| swCapWr | input | 1 | Software capture register write strobe |
| swCapSec | input | 2 | Security state of the software capture write |
| monSec | input | 2*NUM_MON | Security state of each monitor |
| capSel | input | 3*NUM_MON | Capture selector per monitor: 0 none, 1..6 line, 7 software |
| lnkSel | input | 3*NUM_MON | Linkage selector per monitor: 0 local, 1..6 line, 7 reserved |
| capOnOvf | input | NUM_MON | Capture on own overflow or linkage event, per monitor |
| evtAsOvf | input | NUM_MON | Treat a matching event as an overflow, per monitor |
| ovfPulse | input | NUM_MON | Overflow pulse from each monitor's counter |
| capPulse | output | NUM_MON | Capture pulse per monitor |
| ovfEvt | output | NUM_MON | Event-as-overflow indication per monitor |

## Verification
Every result is due one clock after its cause. This holds for external strobes, software writes, linked overflows and private overflow captures, because each cause passes through exactly one register before the per-monitor decode. The bench drives a stimulus on a falling edge and samples the outputs on the next falling edge, after the one rising edge that registers it. Then it clears the stimulus, so the following sample also shows the pulse has ended. Configuration changes only together with a stimulus, so the model sees the same settings the design decodes.

// File: rtl/capevt_pkg.sv
package capevt_pkg;
  localparam int NUM_EVT = 6;
  localparam int SEL_W   = 3;
  localparam int SEC_W   = 2;

  localparam logic [SEL_W-1:0] SEL_NONE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SW   = 3'd7;

  typedef struct packed {
    logic [NUM_EVT-1:0] evtLine;
    logic               swCap;
    logic [SEC_W-1:0]   swSec;
  } strobe_t;
endpackage

// File: rtl/capevt_ctrl.sv
module capevt_ctrl
  import capevt_pkg::*;
#(
  parameter int                 NUM_MON    = 4,
  parameter logic [NUM_EVT-1:0] EXT_MASK   = 6'b000001,
  parameter bit                 HAS_SW_CAP = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_EVT-1:0]       extEvt,
  input  logic                     swCapWr,
  input  logic [SEC_W-1:0]         swCapSec,
  input  logic [NUM_MON*SEL_W-1:0] lnkSel,
  input  logic [NUM_MON-1:0]       ovfPulse,
  output strobe_t                  strobe,
  output logic [NUM_MON-1:0]       ownOvf,
  output logic [NUM_MON*SEL_W-1:0] selfLine
);
  logic [NUM_MON-1:0]       linkHit [NUM_EVT];
  logic [NUM_EVT-1:0]       lineNext;
  logic [NUM_MON*SEL_W-1:0] selfNext;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_line
    for (genvar m = 0; m < NUM_MON; m++) begin : g_src
      assign linkHit[k][m] = ovfPulse[m] &&
                             (lnkSel[m*SEL_W +: SEL_W] == SEL_W'(k + 1));
    end
    if (EXT_MASK[k]) begin : g_impl
      assign lineNext[k] = extEvt[k] || (|linkHit[k]);
    end else begin : g_absent
      assign lineNext[k] = 1'b0;
    end
  end

  for (genvar m = 0; m < NUM_MON; m++) begin : g_self
    logic [SEL_W-1:0] ls;
    assign ls = lnkSel[m*SEL_W +: SEL_W];
    assign selfNext[m*SEL_W +: SEL_W] =
      (ovfPulse[m] && ls != SEL_NONE && ls != SEL_SW) ? ls : SEL_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe   <= '0;
      ownOvf   <= '0;
      selfLine <= '0;
    end else begin
      strobe.evtLine <= lineNext;
      strobe.swCap   <= swCapWr && HAS_SW_CAP;
      strobe.swSec   <= swCapSec;
      ownOvf         <= ovfPulse;
      selfLine       <= selfNext;
    end
  end
endmodule

// File: rtl/capevt_dp.sv
module capevt_dp
  import capevt_pkg::*;
#(
  parameter int NUM_MON = 4
) (
  input  strobe_t                  strobe,
  input  logic [NUM_MON-1:0]       ownOvf,
  input  logic [NUM_MON*SEL_W-1:0] selfLine,
  input  logic [NUM_MON*SEC_W-1:0] monSec,
  input  logic [NUM_MON*SEL_W-1:0] capSel,
  input  logic [NUM_MON-1:0]       capOnOvf,
  input  logic [NUM_MON-1:0]       evtAsOvf,
  output logic [NUM_MON-1:0]       capPulse,
  output logic [NUM_MON-1:0]       ovfEvt
);
  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    logic [SEL_W-1:0]        cs;
    logic                    swMatch;
    logic [(1<<SEL_W)-1:0]   srcVec;
    logic                    evHit;

    assign cs      = capSel[m*SEL_W +: SEL_W];
    assign swMatch = strobe.swCap && (strobe.swSec == monSec[m*SEC_W +: SEC_W]);
    assign srcVec  = {swMatch, strobe.evtLine, 1'b0};
    assign evHit   = srcVec[cs] && (selfLine[m*SEL_W +: SEL_W] != cs);

    assign capPulse[m] = (ownOvf[m] && capOnOvf[m]) ||
                         (evHit && (!evtAsOvf[m] || capOnOvf[m]));
    assign ovfEvt[m]   = evHit && evtAsOvf[m];
  end
endmodule

// File: rtl/capevt_router.sv
module capevt_router
  import capevt_pkg::*;
#(
  parameter int                 NUM_MON    = 4,
  parameter logic [NUM_EVT-1:0] EXT_MASK   = 6'b000001,
  parameter bit                 HAS_SW_CAP = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_EVT-1:0]       extEvt,
  input  logic                     swCapWr,
  input  logic [SEC_W-1:0]         swCapSec,
  input  logic [NUM_MON*SEC_W-1:0] monSec,
  input  logic [NUM_MON*SEL_W-1:0] capSel,
  input  logic [NUM_MON*SEL_W-1:0] lnkSel,
  input  logic [NUM_MON-1:0]       capOnOvf,
  input  logic [NUM_MON-1:0]       evtAsOvf,
  input  logic [NUM_MON-1:0]       ovfPulse,
  output logic [NUM_MON-1:0]       capPulse,
  output logic [NUM_MON-1:0]       ovfEvt
);
  strobe_t                  strobe;
  logic [NUM_MON-1:0]       ownOvf;
  logic [NUM_MON*SEL_W-1:0] selfLine;

  capevt_ctrl #(
    .NUM_MON(NUM_MON), .EXT_MASK(EXT_MASK), .HAS_SW_CAP(HAS_SW_CAP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .extEvt(extEvt), .swCapWr(swCapWr),
    .swCapSec(swCapSec), .lnkSel(lnkSel), .ovfPulse(ovfPulse),
    .strobe(strobe), .ownOvf(ownOvf), .selfLine(selfLine)
  );

  capevt_dp #(.NUM_MON(NUM_MON)) uDp (
    .strobe(strobe), .ownOvf(ownOvf), .selfLine(selfLine), .monSec(monSec),
    .capSel(capSel), .capOnOvf(capOnOvf), .evtAsOvf(evtAsOvf),
    .capPulse(capPulse), .ovfEvt(ovfEvt)
  );
endmodule

// File: rtl/capevt_router_chk.sv
module capevt_router_chk
  import capevt_pkg::*;
#(
  parameter int                 NUM_MON  = 4,
  parameter logic [NUM_EVT-1:0] EXT_MASK = 6'b000001
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_MON*SEL_W-1:0] capSel,
  input logic [NUM_MON-1:0]       capOnOvf,
  input logic [NUM_MON-1:0]       evtAsOvf,
  input logic [NUM_MON-1:0]       ovfPulse,
  input logic [NUM_MON-1:0]       capPulse,
  input logic [NUM_MON-1:0]       ovfEvt
);
  always_comb begin
    if (!rstN) begin
      // R1
      quiet_in_reset_chk: assert (capPulse == '0 && ovfEvt == '0);
    end
  end

  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    // R2
    no_selzero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (capSel[m*SEL_W +: SEL_W] == SEL_NONE && !capOnOvf[m])
        |-> (!capPulse[m] && !ovfEvt[m]));

    // R8
    own_ovf_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
      ovfPulse[m] |=> (!capOnOvf[m] || capPulse[m]));

    // R9
    ovf_evt_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
      ovfEvt[m] |-> evtAsOvf[m]);

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_ln
      if (!EXT_MASK[k]) begin : g_absent
        // R4
        absent_line_chk: assert property (@(posedge clk) disable iff (!rstN)
          (capSel[m*SEL_W +: SEL_W] == SEL_W'(k + 1) && !capOnOvf[m])
            |-> (!capPulse[m] && !ovfEvt[m]));
      end
    end
  end
endmodule

bind capevt_router capevt_router_chk #(
  .NUM_MON(NUM_MON), .EXT_MASK(EXT_MASK)
) uChk (
  .clk(clk), .rstN(rstN), .capSel(capSel), .capOnOvf(capOnOvf),
  .evtAsOvf(evtAsOvf), .ovfPulse(ovfPulse), .capPulse(capPulse),
  .ovfEvt(ovfEvt)
);

// File: tb/capevt_router_test.sv
module capevt_router_test;
  localparam int         NM   = 4;
  localparam logic [5:0] MASK = 6'b101101;  // lines 1,3,4,6 present

  logic            clk = 1'b0;
  logic            rstN;
  logic [5:0]      extEvt;
  logic            swCapWr;
  logic [1:0]      swCapSec;
  logic [NM*2-1:0] monSec;
  logic [NM*3-1:0] capSel, lnkSel;
  logic [NM-1:0]   capOnOvf, evtAsOvf, ovfPulse;
  logic [NM-1:0]   capPulse, ovfEvt;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  capevt_router #(.NUM_MON(NM), .EXT_MASK(MASK), .HAS_SW_CAP(1'b1)) uut (
    .clk(clk), .rstN(rstN), .extEvt(extEvt), .swCapWr(swCapWr),
    .swCapSec(swCapSec), .monSec(monSec), .capSel(capSel), .lnkSel(lnkSel),
    .capOnOvf(capOnOvf), .evtAsOvf(evtAsOvf), .ovfPulse(ovfPulse),
    .capPulse(capPulse), .ovfEvt(ovfEvt)
  );

  // Expected outputs for monitor m, one cycle after the inputs now applied.
  function automatic void model(input int m, output logic eCap,
                                output logic eOvf, output string tag);
    logic [5:0] line;
    logic [2:0] cs, ls, selfL;
    logic hit, own, linkOnly, suppressed;
    line = extEvt;
    linkOnly = 1'b0;
    for (int j = 0; j < NM; j++) begin
      ls = lnkSel[j*3 +: 3];
      if (ovfPulse[j] && ls >= 3'd1 && ls <= 3'd6) line[ls-1] = 1'b1;
    end
    line = line & MASK;
    cs = capSel[m*3 +: 3];
    ls = lnkSel[m*3 +: 3];
    selfL = (ovfPulse[m] && ls >= 3'd1 && ls <= 3'd6) ? ls : 3'd0;
    hit = 1'b0;
    suppressed = 1'b0;
    if (cs >= 3'd1 && cs <= 3'd6) begin
      hit = line[cs-1];
      linkOnly = hit && !extEvt[cs-1];
      if (hit && selfL == cs) begin hit = 1'b0; suppressed = 1'b1; end
    end else if (cs == 3'd7) begin
      hit = swCapWr && (swCapSec == monSec[m*2 +: 2]);
    end
    own  = ovfPulse[m] && capOnOvf[m];
    eCap = own || (hit && (!evtAsOvf[m] || capOnOvf[m]));
    eOvf = hit && evtAsOvf[m];
    if (own)                          tag = "R8";
    else if (suppressed)              tag = "R10";
    else if (cs == 3'd0)              tag = "R2";
    else if (cs == 3'd7)              tag = "R5";
    else if (!MASK[cs-1])             tag = "R4";
    else if (evtAsOvf[m])             tag = "R9";
    else if (linkOnly)                tag = "R6";
    else                              tag = "R3";
  endfunction

  task automatic clearStim();
    extEvt = '0; swCapWr = 1'b0; swCapSec = '0; ovfPulse = '0;
  endtask

  // Wait for the registering edge, sample at the falling edge, compare, clear.
  task automatic step(input string forceTag);
    logic [NM-1:0] eCap, eOvf;
    string tags [NM];
    for (int m = 0; m < NM; m++) model(m, eCap[m], eOvf[m], tags[m]);
    @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      string t;
      t = (forceTag != "") ? forceTag : tags[m];
      compared++;
      if (capPulse[m] !== eCap[m]) begin
        mismatched++;
        $display("FAIL %s mon%0d capPulse actual %b expected %b", t, m,
                 capPulse[m], eCap[m]);
      end
      compared++;
      if (ovfEvt[m] !== eOvf[m]) begin
        mismatched++;
        $display("FAIL %s mon%0d ovfEvt actual %b expected %b", t, m,
                 ovfEvt[m], eOvf[m]);
      end
    end
    clearStim();
  endtask

  task automatic setMon(input int m, input logic [2:0] cs, input logic [2:0] ls,
                        input logic [1:0] sec, input logic co, input logic eo);
    capSel[m*3 +: 3] = cs;
    lnkSel[m*3 +: 3] = ls;
    monSec[m*2 +: 2] = sec;
    capOnOvf[m] = co;
    evtAsOvf[m] = eo;
  endtask

  task automatic checkIdle(input string t);
    compared++;
    if (capPulse !== '0 || ovfEvt !== '0) begin
      mismatched++;
      $display("FAIL %s outputs actual %b/%b expected 0/0", t, capPulse, ovfEvt);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    clearStim();
    capSel = '0; lnkSel = '0; monSec = '0; capOnOvf = '0; evtAsOvf = '0;
    for (int m = 0; m < NM; m++) setMon(m, 3'd1, 3'd0, 2'd0, 1'b1, 1'b0);
    extEvt = 6'h3f; ovfPulse = '1; swCapWr = 1'b1;
    repeat (3) @(negedge clk);
    checkIdle("R1");  // R1: busy inputs during reset, outputs stay low
    clearStim();
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");

    // R3: line 1 external strobe
    setMon(0, 3'd1, 3'd0, 2'd0, 1'b0, 1'b0);
    setMon(1, 3'd3, 3'd0, 2'd1, 1'b0, 1'b0);
    setMon(2, 3'd0, 3'd0, 2'd2, 1'b0, 1'b0);
    setMon(3, 3'd2, 3'd0, 2'd3, 1'b0, 1'b0);
    extEvt = 6'b000001; step("");
    step("");                             // pulse ends
    extEvt = 6'b000101; step("");         // R3 on line 3
    // R4: line 2 absent
    extEvt = 6'b000010; step("R4");
    // R2: selector 0 sees nothing
    extEvt = 6'h3f; swCapWr = 1'b1; step("");
    // R5: software capture, matching and non-matching state
    setMon(0, 3'd7, 3'd0, 2'd0, 1'b0, 1'b0);
    setMon(1, 3'd7, 3'd0, 2'd1, 1'b0, 1'b0);
    swCapWr = 1'b1; swCapSec = 2'd1; step("R5");
    swCapWr = 1'b1; swCapSec = 2'd2; step("R5");
    // R6: monitor 2 links to line 4, monitors 0 and 1 select line 4
    setMon(0, 3'd4, 3'd0, 2'd0, 1'b0, 1'b0);
    setMon(1, 3'd4, 3'd0, 2'd1, 1'b0, 1'b0);
    setMon(2, 3'd0, 3'd4, 2'd2, 1'b0, 1'b0);
    ovfPulse = 4'b0100; step("R6");
    // R7: reserved and local linkage drive nothing
    setMon(2, 3'd0, 3'd7, 2'd2, 1'b0, 1'b0);
    setMon(3, 3'd4, 3'd0, 2'd3, 1'b0, 1'b0);
    ovfPulse = 4'b1100; step("R7");
    // R4: linkage onto absent line 5
    setMon(0, 3'd5, 3'd0, 2'd0, 1'b0, 1'b0);
    setMon(2, 3'd0, 3'd5, 2'd2, 1'b0, 1'b0);
    ovfPulse = 4'b0100; step("R4");
    // R8: private capture on own overflow
    setMon(3, 3'd0, 3'd0, 2'd3, 1'b1, 1'b0);
    ovfPulse = 4'b1000; step("R8");
    // R10: monitor 1 drives line 6 and selects it, with external strobe too
    setMon(0, 3'd6, 3'd0, 2'd0, 1'b0, 1'b0);
    setMon(1, 3'd6, 3'd6, 2'd1, 1'b0, 1'b0);
    extEvt = 6'b100000; ovfPulse = 4'b0010; step("R10");
    // R9: event as overflow, with and without capture-on-overflow
    setMon(0, 3'd1, 3'd0, 2'd0, 1'b0, 1'b1);
    setMon(1, 3'd1, 3'd0, 2'd1, 1'b1, 1'b1);
    extEvt = 6'b000001; step("R9");
    // R11: external and two linked overflows on line 3 at once
    setMon(0, 3'd3, 3'd0, 2'd0, 1'b0, 1'b0);
    setMon(1, 3'd0, 3'd3, 2'd1, 1'b0, 1'b0);
    setMon(2, 3'd0, 3'd3, 2'd2, 1'b0, 1'b0);
    setMon(3, 3'd3, 3'd0, 2'd3, 1'b0, 1'b0);
    extEvt = 6'b000100; ovfPulse = 4'b0110; step("R11");
    step("R11");

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      if (($urandom % 16) == 0 || c == 0) begin
        for (int m = 0; m < NM; m++)
          setMon(m, 3'($urandom), 3'($urandom), 2'($urandom),
                 1'(($urandom % 4) == 0), 1'(($urandom % 4) == 0));
      end
      for (int k = 0; k < 6; k++) extEvt[k] = (($urandom % 4) == 0);
      for (int m = 0; m < NM; m++) ovfPulse[m] = (($urandom % 6) == 0);
      swCapWr = (($urandom % 4) == 0);
      swCapSec = 2'($urandom);
      step("");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule